// File: doc/BRIEF.md
# Serial Clock Synthesizer Programming Shifter

This block loads an external frequency synthesizer through three output pins: a serial data line, a strobe line and a clock pulse line. A host hands it one programming request: a clock-select index, a feedback divider value and a post-divider value. The block packs these three fields into one word, inverts a fixed set of bits by XOR with a toggle mask, waits a long settling interval, and then sends the word serially, least significant bit first. Each bit takes two equal phases. In the first phase the data pin carries the bit and the strobe pin is high. In the second phase the pulse pin is also high, and the synthesizer latches the bit on that rising edge.

Sending stops on the value of what remains, not on a bit count. After each bit the word shifts right by one, and the transfer continues while the remainder is non-zero. The toggle mask sets the top bit of the word, so every full request sends the whole word. When the last bit is done, the pins settle to a rest level with strobe high. The block then gives a one-cycle completion pulse. All timing is counted in ticks of an external 1 us enable input.

The request interface is a valid/ready handshake. `cfg_ready` is high exactly while no transfer is in progress. A request is taken on a clock edge where both `cfg_valid` and `cfg_ready` are high, and the fields are captured on that edge. While a transfer runs, `cfg_ready` stays low and `cfg_valid` and the field inputs have no effect. A host that holds `cfg_valid` high has its request taken on the first edge after the current transfer finishes.

Top module: `clksyn_prog_shifter`

## Requirements
- R1: The transmitted word is (pdiv << (SEL_W+FBDIV_W)) | (fbdiv << SEL_W) | sel, zero-extended to WORD_W bits and then XORed with TOGGLE (sel in the lowest bits, then fbdiv, then pdiv).
- R2: cfg_ready is high exactly while busy is low. A request is taken only when cfg_valid and cfg_ready are both high at an edge, and busy rises on that edge. Fields presented while busy do not change the word being sent.
- R3: No bit phase begins until SETTLE_TICKS ticks have passed after acceptance. With tick high every cycle, the first rising edge of pin_pulse is seen SETTLE_TICKS+PHASE_TICKS cycles after the accepting edge.
- R4: Bits go out least significant first. Bit k of the word is on pin_data at the k-th rising edge of pin_pulse.
- R5: A bit is sent while the unsent remainder of the word is non-zero. The number of bits equals the index of the highest set bit plus one, and an all-zero word sends no bits.
- R6: Each bit spends PHASE_TICKS ticks with pin_strobe high and pin_pulse low, then PHASE_TICKS ticks with pin_pulse also high. pin_pulse is never high without pin_strobe, and pin_data does not change while pin_pulse is high or on its rising edge.
- R7: After the last bit, pin_data and pin_pulse are low and pin_strobe is high, and the pins hold that rest level until the next transfer drives a bit.
- R8: done is high for exactly one cycle per transfer, and busy falls on the same edge. With tick high every cycle, done is seen SETTLE_TICKS + 2*PHASE_TICKS*nbits + 1 cycles after the accepting edge.
- R9: Settle and phase timing advance only on cycles where tick is high. With tick held low, a busy transfer keeps its pins unchanged.
- R10: After reset, all three pins are low, busy and done are low, and cfg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable, once per microsecond |
| cfg_valid | input | 1 | Programming request present |
| cfg_ready | output | 1 | Block can take a request (not busy) |
| cfg_sel | input | SEL_W | Clock-select index field |
| cfg_fbdiv | input | FBDIV_W | Feedback divider field |
| cfg_pdiv | input | PDIV_W | Post-divider code field |
| pin_data | output | 1 | Serial data to the synthesizer |
| pin_strobe | output | 1 | Strobe (enable) line |
| pin_pulse | output | 1 | Bit clock pulse line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong word register or a wrong mask changes which bits are latched on pulse edges, so it shows within the first few bits after the settle delay. A wrong stop test gives a bit count that differs from the position of the highest set bit. A fault in the down-counter or the sequencer moves the first pulse edge or the done pulse away from its computed cycle, and an error in the phase order shows as a pulse without strobe, or as data moving under a high pulse, within one bit time. A broken handshake either lets a second request overwrite the word in the middle of a transfer, or leaves the block stuck busy, and the bench then sees no done.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  // sequencer states of one programming transfer
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_PHASE_A = 3'd2,
    ST_PHASE_B = 3'd3,
    ST_REST    = 3'd4
  } seq_state_t;

  // timer preload choice
  typedef enum logic {
    LD_SETTLE = 1'b0,
    LD_PHASE  = 1'b1
  } tmr_sel_t;

endpackage

// File: rtl/clksyn_word_pack.sv
module clksyn_word_pack #(
  parameter int SEL_W   = 4,
  parameter int FBDIV_W = 9,
  parameter int PDIV_W  = 3,
  parameter int WORD_W  = 20,
  parameter logic [WORD_W-1:0] TOGGLE = '0
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [FBDIV_W-1:0] fbdiv,
  input  logic [PDIV_W-1:0]  pdiv,
  output logic [WORD_W-1:0]  word
);

  localparam int USED_W = SEL_W + FBDIV_W + PDIV_W;

  logic [WORD_W-1:0] raw;

  generate
    if (USED_W < WORD_W) begin : g_pad
      assign raw = {{(WORD_W-USED_W){1'b0}}, pdiv, fbdiv, sel};
    end else begin : g_fit
      logic [USED_W-1:0] full;
      assign full = {pdiv, fbdiv, sel};
      assign raw  = full[WORD_W-1:0];
    end
  endgenerate

  assign word = raw ^ TOGGLE;

endmodule

// File: rtl/clksyn_us_timer.sv
module clksyn_us_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  // last tick of the loaded interval
  assign expire = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/clksyn_shreg.sv
module clksyn_shreg #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              shift,
  output logic              cur_bit,
  output logic              next_bit,
  output logic              rem_nz,
  output logic              next_nz
);

  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_next;

  assign sr_next  = sr_q >> 1;
  assign cur_bit  = sr_q[0];
  assign next_bit = sr_next[0];
  assign rem_nz   = |sr_q;
  assign next_nz  = |sr_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_val;
    end else if (shift) begin
      sr_q <= sr_next;
    end
  end

endmodule

// File: rtl/clksyn_seq.sv
module clksyn_seq
  import clksyn_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     expire,
  input  logic     cur_bit,
  input  logic     next_bit,
  input  logic     rem_nz,
  input  logic     next_nz,
  output logic     word_load,
  output logic     word_shift,
  output logic     tmr_load,
  output tmr_sel_t tmr_sel,
  output logic     pin_data,
  output logic     pin_strobe,
  output logic     pin_pulse,
  output logic     busy,
  output logic     done
);

  seq_state_t state_q;

  // control strobes to the datapath
  always_comb begin
    word_load  = 1'b0;
    word_shift = 1'b0;
    tmr_load   = 1'b0;
    tmr_sel    = LD_PHASE;
    unique case (state_q)
      ST_IDLE: begin
        word_load = accept;
        tmr_load  = accept;
        tmr_sel   = LD_SETTLE;
      end
      ST_SETTLE:  tmr_load = expire && rem_nz;
      ST_PHASE_A: tmr_load = expire;
      ST_PHASE_B: begin
        word_shift = expire;
        tmr_load   = expire && next_nz;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pin_data   <= 1'b0;
      pin_strobe <= 1'b0;
      pin_pulse  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_SETTLE;
            busy    <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (expire) begin
            if (rem_nz) begin
              state_q    <= ST_PHASE_A;
              pin_data   <= cur_bit;
              pin_strobe <= 1'b1;
              pin_pulse  <= 1'b0;
            end else begin
              state_q    <= ST_REST;
              pin_data   <= 1'b0;
              pin_strobe <= 1'b1;
              pin_pulse  <= 1'b0;
            end
          end
        end
        ST_PHASE_A: begin
          if (expire) begin
            state_q   <= ST_PHASE_B;
            pin_pulse <= 1'b1;
          end
        end
        ST_PHASE_B: begin
          if (expire) begin
            pin_pulse <= 1'b0;
            if (next_nz) begin
              state_q  <= ST_PHASE_A;
              pin_data <= next_bit;
            end else begin
              state_q    <= ST_REST;
              pin_data   <= 1'b0;
              pin_strobe <= 1'b1;
            end
          end
        end
        ST_REST: begin
          state_q <= ST_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clksyn_prog_shifter.sv
module clksyn_prog_shifter
  import clksyn_pkg::*;
#(
  parameter int SEL_W        = 4,
  parameter int FBDIV_W      = 9,
  parameter int PDIV_W       = 3,
  parameter int WORD_W       = 20,
  parameter logic [WORD_W-1:0] TOGGLE = 20'h9_0000,
  parameter int SETTLE_TICKS = 50000,
  parameter int PHASE_TICKS  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [FBDIV_W-1:0] cfg_fbdiv,
  input  logic [PDIV_W-1:0]  cfg_pdiv,
  output logic               pin_data,
  output logic               pin_strobe,
  output logic               pin_pulse,
  output logic               busy,
  output logic               done
);

  localparam int MAX_TICKS = (SETTLE_TICKS > PHASE_TICKS) ? SETTLE_TICKS : PHASE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [WORD_W-1:0] packed_word;
  logic              accept;
  logic              word_load, word_shift;
  logic              tmr_load, expire;
  tmr_sel_t          tmr_sel;
  logic [CNT_W-1:0]  tmr_val;
  logic              cur_bit, next_bit, rem_nz, next_nz;

  assign cfg_ready = !busy;
  assign accept    = cfg_valid && cfg_ready;
  assign tmr_val   = (tmr_sel == LD_SETTLE) ? CNT_W'(SETTLE_TICKS) : CNT_W'(PHASE_TICKS);

  clksyn_word_pack #(
    .SEL_W(SEL_W), .FBDIV_W(FBDIV_W), .PDIV_W(PDIV_W),
    .WORD_W(WORD_W), .TOGGLE(TOGGLE)
  ) u_pack (
    .sel(cfg_sel), .fbdiv(cfg_fbdiv), .pdiv(cfg_pdiv), .word(packed_word)
  );

  clksyn_us_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(tmr_load), .load_val(tmr_val), .expire(expire)
  );

  clksyn_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(word_load), .load_val(packed_word),
    .shift(word_shift), .cur_bit(cur_bit), .next_bit(next_bit),
    .rem_nz(rem_nz), .next_nz(next_nz)
  );

  clksyn_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .expire(expire),
    .cur_bit(cur_bit), .next_bit(next_bit), .rem_nz(rem_nz), .next_nz(next_nz),
    .word_load(word_load), .word_shift(word_shift),
    .tmr_load(tmr_load), .tmr_sel(tmr_sel),
    .pin_data(pin_data), .pin_strobe(pin_strobe), .pin_pulse(pin_pulse),
    .busy(busy), .done(done)
  );

endmodule

// File: rtl/clksyn_prog_shifter_chk.sv
module clksyn_prog_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_valid,
  input logic cfg_ready,
  input logic pin_data,
  input logic pin_strobe,
  input logic pin_pulse,
  input logic busy,
  input logic done
);

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready) |=> busy);

  // R6
  pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pulse |-> pin_strobe);

  // R6
  data_steady_at_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pulse && $past(pin_pulse)) |-> $stable(pin_data));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_fall_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pin_strobe && !pin_pulse && !pin_data && !busy));

endmodule

bind clksyn_prog_shifter clksyn_prog_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .pin_data(pin_data), .pin_strobe(pin_strobe), .pin_pulse(pin_pulse),
  .busy(busy), .done(done)
);

// File: tb/test_clksyn_prog_shifter.sv
module test_clksyn_prog_shifter;

  localparam int SW = 2, FW = 4, PW = 2, WW = 12;
  localparam logic [WW-1:0] TOG = 12'h8A5;
  localparam int ST = 5, PH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic cfg_valid = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [FW-1:0] cfg_fbdiv = '0;
  logic [PW-1:0] cfg_pdiv = '0;

  logic rdy1, d1, s1, p1, b1, dn1;
  logic rdy2, d2, s2, p2, b2, dn2;
  logic v1, v2;

  always #2.5 clk = ~clk;

  assign v1 = cfg_valid && !use2;
  assign v2 = cfg_valid && use2;

  logic use2 = 1'b0;

  clksyn_prog_shifter #(.SEL_W(SW), .FBDIV_W(FW), .PDIV_W(PW), .WORD_W(WW),
    .TOGGLE(TOG), .SETTLE_TICKS(ST), .PHASE_TICKS(PH)) i_clksyn_prog_shifter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_valid(v1), .cfg_ready(rdy1),
    .cfg_sel(cfg_sel), .cfg_fbdiv(cfg_fbdiv), .cfg_pdiv(cfg_pdiv),
    .pin_data(d1), .pin_strobe(s1), .pin_pulse(p1), .busy(b1), .done(dn1));

  clksyn_prog_shifter #(.SEL_W(SW), .FBDIV_W(FW), .PDIV_W(PW), .WORD_W(WW),
    .TOGGLE('0), .SETTLE_TICKS(ST), .PHASE_TICKS(PH)) i_clksyn_prog_shifter_nomask (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_valid(v2), .cfg_ready(rdy2),
    .cfg_sel(cfg_sel), .cfg_fbdiv(cfg_fbdiv), .cfg_pdiv(cfg_pdiv),
    .pin_data(d2), .pin_strobe(s2), .pin_pulse(p2), .busy(b2), .done(dn2));

  int checks = 0;
  int fails = 0;
  int gcnt = 0;

  // monitor state
  int k, alen, blen, ph_err, first_rise, done_g;
  logic [WW-1:0] rx;
  logic prev_pulse, done_seen;

  wire m_data  = use2 ? d2 : d1;
  wire m_strb  = use2 ? s2 : s1;
  wire m_pulse = use2 ? p2 : p1;
  wire m_busy  = use2 ? b2 : b1;
  wire m_done  = use2 ? dn2 : dn1;
  wire m_rdy   = use2 ? rdy2 : rdy1;

  always @(posedge clk) gcnt <= gcnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_pulse && !m_strb) ph_err++;
      if (m_pulse && prev_pulse && m_data != rx[k-1]) ph_err++;
      if (m_pulse && !prev_pulse) begin
        if (k > 0 && alen != PH) ph_err++;
        if (k == 0) first_rise = gcnt;
        if (k < WW) rx[k] = m_data;
        k++;
        alen = 0;
        blen = 1;
      end else if (m_pulse) begin
        blen++;
      end else begin
        if (prev_pulse && blen != PH) ph_err++;
        if (m_strb) alen++;
      end
      prev_pulse = m_pulse;
      if (m_done && !done_seen) begin
        done_seen = 1'b1;
        done_g = gcnt;
        if (m_busy) ph_err++;
      end
    end
  end

  always @(posedge clk) begin
    if (gcnt > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", gcnt, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_xfer(input bit on2, input int sel, input int fb, input int pd,
                          input bit hold_tick, input bit poke);
    logic [WW-1:0] w;
    int n, start;
    logic ps, pp, pd0;
    w = WW'((pd << (SW+FW)) | (fb << SW) | sel);
    if (!on2) w = w ^ TOG;
    n = 0;
    for (int i = 0; i < WW; i++) if (w[i]) n = i + 1;
    @(negedge clk);
    use2 = on2;
    cfg_sel = SW'(sel); cfg_fbdiv = FW'(fb); cfg_pdiv = PW'(pd);
    cfg_valid = 1'b1;
    if (hold_tick) tick = 1'b0;
    @(posedge clk);
    k = 0; rx = '0; alen = 0; blen = 0; ph_err = 0; first_rise = -1;
    done_g = -1; done_seen = 1'b0; prev_pulse = 1'b0;
    @(negedge clk);
    start = gcnt;
    cfg_valid = 1'b0;
    if (hold_tick) begin
      ps = m_strb; pp = m_pulse; pd0 = m_data;
      repeat (20) @(negedge clk);
      // R9: nothing advances without tick
      chk(m_busy && m_strb == ps && m_pulse == pp && m_data == pd0 && k == 0,
          "R9 frozen without tick", k, 0);
      tick = 1'b1;
    end
    if (poke) begin
      cfg_sel = ~cfg_sel; cfg_fbdiv = ~cfg_fbdiv; cfg_pdiv = ~cfg_pdiv;
      cfg_valid = 1'b1;
      repeat (8) @(negedge clk);
      // R2: not ready while busy
      chk(!m_rdy && m_busy, "R2 ready low while busy", int'(m_rdy), 0);
      cfg_valid = 1'b0;
    end
    for (int c = 0; c < 5000 && !done_seen; c++) @(negedge clk);
    // R1 R4: received bits, LSB first, equal packed and masked word
    chk(rx == w, "R1/R4 word", int'(rx), int'(w));
    // R5: bit count from highest set bit
    chk(k == n, "R5 bit count", k, n);
    // R6: phase shape and lengths
    chk(ph_err == 0, "R6 phase errors", ph_err, 0);
    if (!hold_tick && !poke) begin
      // R8: done latency, busy low with done
      chk(done_g - start == ST + 2*PH*n + 1, "R8 done latency", done_g - start, ST + 2*PH*n + 1);
      // R3: first pulse after settle plus one phase
      if (n > 0) chk(first_rise - start == ST + PH, "R3 first pulse", first_rise - start, ST + PH);
    end
    @(negedge clk);
    // R7: rest level held after done, R2 ready again
    chk(m_strb && !m_data && !m_pulse && m_rdy && !m_done, "R7 rest level",
        {m_strb, m_data, m_pulse, m_rdy}, 4'b1001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!d1 && !s1 && !p1 && !b1 && !dn1 && rdy1, "R10 reset outputs",
        {d1, s1, p1, b1, dn1, rdy1}, 1);
    rst_n = 1'b1;
    // R1 R3 R4 R5 R6 R7 R8: exhaustive field sweep on the masked instance
    for (int pd = 0; pd < (1 << PW); pd++)
      for (int fb = 0; fb < (1 << FW); fb++)
        for (int sl = 0; sl < (1 << SW); sl++)
          run_xfer(1'b0, sl, fb, pd, 1'b0, 1'b0);
    // R5: threshold stop on the unmasked instance, including empty word
    run_xfer(1'b1, 0, 0, 0, 1'b0, 1'b0);
    run_xfer(1'b1, 1, 0, 0, 1'b0, 1'b0);
    run_xfer(1'b1, 0, 1, 0, 1'b0, 1'b0);
    run_xfer(1'b1, 2, 5, 0, 1'b0, 1'b0);
    run_xfer(1'b1, 3, 15, 3, 1'b0, 1'b0);
    // R9: tick gating
    run_xfer(1'b0, 1, 9, 2, 1'b1, 1'b0);
    // R2: requests offered while busy are ignored
    run_xfer(1'b0, 2, 6, 1, 1'b0, 1'b1);
    run_xfer(1'b1, 1, 3, 0, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule